// File: doc/BRIEF.md
# Comparator Event Timer Channel

This block is a single event channel that watches a shared, free-running main counter and raises an interrupt request when the counter reaches the channel's comparator. The counter, and a strobe marking each counter increment, come from outside the block. A global enable, also from outside, gates every channel together. Software reaches the channel through four 32-bit words: a low configuration word, a read-only high configuration word, and the two halves of the comparator.

The channel runs either one-shot or periodic. In periodic mode it keeps a hidden reload interval that is separate from the comparator. A self-clearing set-value bit lets software load the comparator and the interval with one write. After each periodic match the comparator steps forward by the interval. A narrow mode restricts matching and the interval arithmetic to the low 32 bits. In narrow one-shot mode the channel also raises an interrupt at the point where the counter's low word rolls over, if that rollover comes before the match.

Top module: `evt_timer_chan`

## Requirements
- R1: After reset, the low configuration word reads 0x30, the comparator reads all ones in both halves, the hidden interval is 0 and `irq_o` is low. Word addresses are 0 for low config, 1 for high config, 2 for comparator low and 3 for comparator high. In the low config word, bit 0 is channel enable, bit 1 is periodic, bit 2 is set-value, bit 3 is narrow, and bits 4 and 5 are the periodic and 64-bit capability flags.
- R2: In one-shot mode, when the counter equals the comparator on a sampled increment, `irq_o` pulses high for one cycle on the following clock edge. The channel then disarms.
- R3: In periodic mode with set-value clear, a write to either comparator half updates only the hidden interval, and the comparator reads back unchanged.
- R4: With set-value set in periodic mode, a comparator write loads both the comparator and the interval. Any write to either comparator half clears set-value.
- R5: The top bit of each interval write is forced to 0. This is bit 31 of the low-half write in narrow mode and bit 63 of the interval otherwise.
- R6: On a periodic match, the channel pulses `irq_o` and adds the interval to the comparator. While the comparator lies behind the counter (by signed difference, 32-bit in narrow mode), it adds the interval once per cycle with no interrupt, until it is no longer behind.
- R7: Writing the low config word with narrow set clears the upper halves of the comparator and the interval. While narrow is set, writes to the comparator high half are ignored and matching uses only the low 32 bits.
- R8: In narrow one-shot mode, if the counter's low word reaches all ones before it reaches the comparator, one interrupt is raised at that point and the real match interrupt follows later.
- R9: A 0-to-1 write of channel enable while the global enable is on arms the channel. A comparator write while both enables are on also arms it. Clearing either enable disarms it.
- R10: When the global enable rises, the channel arms only if channel enable is set and the comparator is not all ones.
- R11: The high config word always reads the routing capability parameter. Bits 4 and 5 of the low word read 1 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Main counter value |
| cnt_tick_i | input | 1 | Counter increments at this edge; match is sampled here |
| glb_en_i | input | 1 | Global enable for all channels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select |
| reg_wdata_i | input | CNT_W/2 | Write data |
| reg_rdata_o | output | CNT_W/2 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the counter steps by at most one per sampled increment. They also assume that software changes the mode bits only while the channel is idle or at a point where re-arming follows. Otherwise a pending wrap state could outlive the mode that created it. The stimulus loads the counter and programs the channel only while the global enable is off, or through writes that re-arm it. While the global enable is on, it drives the increment strobe every cycle. Interrupt positions are taken from the counter value the design sampled.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    WA_CFG_LO = 2'd0,
    WA_CFG_HI = 2'd1,
    WA_CMP_LO = 2'd2,
    WA_CMP_HI = 2'd3
  } word_addr_e;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_PER  = 1;
  localparam int unsigned CB_SETV = 2;
  localparam int unsigned CB_NAR  = 3;
  localparam int unsigned CB_PCAP = 4;
  localparam int unsigned CB_SCAP = 5;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  localparam int unsigned DW = CNT_W / 2,
  parameter logic [DW-1:0] ROUTE_CAP = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             adv_i,
  output logic [DW-1:0]    rdata_o,
  output logic             en_o,
  output logic             per_o,
  output logic             nar_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             prd_zero_o,
  output logic             arm_req_o
);
  logic             en_q, per_q, setv_q, nar_q, arm_req_q;
  logic [CNT_W-1:0] cmp_q, prd_q;
  logic [DW-1:0]    cmp_lo_sum;
  logic             cmp_wr;

  assign cmp_lo_sum = cmp_q[DW-1:0] + prd_q[DW-1:0];
  assign cmp_wr     = ~per_q | setv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      per_q     <= 1'b0;
      setv_q    <= 1'b0;
      nar_q     <= 1'b0;
      arm_req_q <= 1'b0;
      cmp_q     <= '1;
      prd_q     <= '0;
    end else begin
      arm_req_q <= 1'b0;
      if (adv_i) cmp_q <= nar_q ? {{DW{1'b0}}, cmp_lo_sum} : cmp_q + prd_q;
      // register writes take priority over the advance
      if (we_i) begin
        unique case (word_addr_e'(addr_i))
          WA_CFG_LO: begin
            en_q   <= wdata_i[CB_EN];
            per_q  <= wdata_i[CB_PER];
            setv_q <= wdata_i[CB_SETV];
            nar_q  <= wdata_i[CB_NAR];
            if (wdata_i[CB_NAR]) begin
              cmp_q[CNT_W-1:DW] <= '0;
              prd_q[CNT_W-1:DW] <= '0;
            end
            arm_req_q <= glb_en_i & wdata_i[CB_EN] & ~en_q;
          end
          WA_CMP_LO: begin
            if (cmp_wr) cmp_q[DW-1:0] <= wdata_i;
            if (per_q) prd_q[DW-1:0] <= nar_q ? {1'b0, wdata_i[DW-2:0]} : wdata_i;
            setv_q    <= 1'b0;
            arm_req_q <= glb_en_i & en_q;
          end
          WA_CMP_HI: begin
            if (!nar_q) begin
              if (cmp_wr) cmp_q[CNT_W-1:DW] <= wdata_i;
              if (per_q) prd_q[CNT_W-1:DW] <= {1'b0, wdata_i[DW-2:0]};
            end
            setv_q    <= 1'b0;
            arm_req_q <= glb_en_i & en_q;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (word_addr_e'(addr_i))
      WA_CFG_LO: begin
        rdata_o[CB_EN]   = en_q;
        rdata_o[CB_PER]  = per_q;
        rdata_o[CB_SETV] = setv_q;
        rdata_o[CB_NAR]  = nar_q;
        rdata_o[CB_PCAP] = 1'b1;
        rdata_o[CB_SCAP] = 1'b1;
      end
      WA_CFG_HI: rdata_o = ROUTE_CAP;
      WA_CMP_LO: rdata_o = cmp_q[DW-1:0];
      WA_CMP_HI: rdata_o = cmp_q[CNT_W-1:DW];
      default:   rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign per_o      = per_q;
  assign nar_o      = nar_q;
  assign cmp_o      = cmp_q;
  assign prd_zero_o = (prd_q == '0);
  assign arm_req_o  = arm_req_q;

  AST_SETV_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (addr_i == WA_CMP_LO || addr_i == WA_CMP_HI) |=> !setv_q); // R4
  AST_NAR_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == WA_CFG_LO && wdata_i[CB_NAR]
      |=> cmp_q[CNT_W-1:DW] == '0 && prd_q[CNT_W-1:DW] == '0); // R7
  AST_PRD_TOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prd_q[CNT_W-1]); // R5
  AST_ADV_PERIODIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> per_q); // R6
endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl #(
  parameter int unsigned CNT_W = 64,
  localparam int unsigned DW = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             glb_en_i,
  input  logic             en_i,
  input  logic             per_i,
  input  logic             nar_i,
  input  logic             prd_zero_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             arm_req_i,
  output logic             adv_o,
  output logic             irq_o
);
  logic             armed_q, wrap_q, glb_q, irq_q;
  logic [DW-1:0]    cnt_lo, cmp_lo, d32, fdist;
  logic [CNT_W-1:0] d64;
  logic             hit, behind, live, reload, arm, wrap_set;
  logic             wrap_hit, hit_ev, fire_rel, fire_one, catch_up, irq_d;

  assign cnt_lo = cnt_i[DW-1:0];
  assign cmp_lo = cmp_i[DW-1:0];
  assign d32    = cmp_lo - cnt_lo;
  assign d64    = cmp_i - cnt_i;
  assign hit    = nar_i ? (cnt_lo == cmp_lo) : (cnt_i == cmp_i);
  assign behind = nar_i ? d32[DW-1] : d64[CNT_W-1];
  assign live   = en_i & glb_en_i;
  assign reload = per_i & ~prd_zero_i;
  assign arm    = live & (arm_req_i | (~glb_q & ~(&cmp_i)));

  // distance to match, at least one tick; wrap if rollover comes first
  assign fdist    = (d32[DW-1] || d32 == '0) ? DW'(1) : d32;
  assign wrap_set = nar_i & ~per_i & ((~cnt_lo) < fdist);

  assign wrap_hit = armed_q & wrap_q & tick_i & (&cnt_lo);
  assign hit_ev   = armed_q & tick_i & hit;
  assign fire_rel = hit_ev & reload;
  assign fire_one = hit_ev & ~reload & ~wrap_q;
  assign catch_up = armed_q & reload & behind;
  assign adv_o    = live & ~arm & (fire_rel | catch_up);
  assign irq_d    = live & ~arm & (wrap_hit | fire_rel | fire_one);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      glb_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      glb_q <= glb_en_i;
      irq_q <= irq_d;
      if (!live) begin
        armed_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (arm) begin
        armed_q <= 1'b1;
        wrap_q  <= wrap_set;
      end else begin
        if (wrap_hit) wrap_q <= 1'b0;
        if (fire_one) armed_q <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(glb_en_i && en_i)); // R9
  AST_WRAP_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrap_q) |-> $past(nar_i && !per_i)); // R8
  AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(per_i) && !$past(wrap_q) |-> !armed_q); // R2
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(per_i) |=> !irq_o || $past(wrap_q)); // R2
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan #(
  parameter int unsigned CNT_W = 64,
  localparam int unsigned DW = CNT_W / 2,
  parameter logic [DW-1:0] ROUTE_CAP = DW'(32'h0000_0A0C)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_tick_i,
  input  logic             glb_en_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  logic             en, per, nar, prd_zero, arm_req, adv;
  logic [CNT_W-1:0] cmp;

  evt_timer_regs #(.CNT_W(CNT_W), .ROUTE_CAP(ROUTE_CAP)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .glb_en_i   (glb_en_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .adv_i      (adv),
    .rdata_o    (reg_rdata_o),
    .en_o       (en),
    .per_o      (per),
    .nar_o      (nar),
    .cmp_o      (cmp),
    .prd_zero_o (prd_zero),
    .arm_req_o  (arm_req)
  );

  evt_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_i),
    .tick_i     (cnt_tick_i),
    .glb_en_i   (glb_en_i),
    .en_i       (en),
    .per_i      (per),
    .nar_i      (nar),
    .prd_zero_i (prd_zero),
    .cmp_i      (cmp),
    .arm_req_i  (arm_req),
    .adv_o      (adv),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/evt_timer_chan_bench.sv
module evt_timer_chan_bench;
  localparam logic [31:0] ROUTE = 32'h0000_0A0C;

  typedef struct packed {
    logic        nar;
    logic [63:0] cnt0;
    logic [63:0] cmp;
    logic [1:0]  nhit;
    logic [63:0] h0;
    logic [63:0] h1;
  } vec_t;

  // one-shot cases: R2 wide, R7 narrow low-word match, R8 wrap interrupt
  localparam vec_t VECS [5] = '{
    '{1'b0, 64'd100,               64'd110,               2'd1, 64'd110,               64'd0},
    '{1'b1, 64'h1_FFFF_FFF0,       64'h10,                2'd2, 64'h1_FFFF_FFFF,       64'h2_0000_0010},
    '{1'b1, 64'h7_0000_0005,       64'h20,                2'd1, 64'h7_0000_0020,       64'd0},
    '{1'b0, 64'hFFFF_FFF0,         64'h1_0000_0005,       2'd1, 64'h1_0000_0005,       64'd0},
    '{1'b1, 64'hFFFF_FFF0,         64'hFFFF_FFF8,         2'd1, 64'hFFFF_FFF8,         64'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        tick = 1'b0, glb = 1'b0, we = 1'b0, ld = 1'b0;
  logic [63:0] ld_val = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          tests = 0, fails = 0, nh = 0;
  logic [63:0] hits [8];
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (ld) cnt <= ld_val;
    else if (tick) cnt <= cnt + 64'd1;
  end

  evt_timer_chan #(.CNT_W(64), .ROUTE_CAP(ROUTE)) u_evt_timer_chan (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_tick_i(tick), .glb_en_i(glb),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic load_cnt(input logic [63:0] v);
    @(negedge clk); ld = 1'b1; ld_val = v;
    @(negedge clk); ld = 1'b0;
  endtask

  // irq seen at negedge belongs to the counter value sampled one edge before
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq && nh < 8) begin hits[nh] = cnt - 64'd1; nh++; end
    end
  endtask

  task automatic start();
    @(negedge clk); glb = 1'b1; tick = 1'b1; nh = 0;
  endtask

  task automatic stop();
    @(negedge clk); glb = 1'b0; tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, rv); chk("R1 cfg lo", rv, 32'h30);
    rd(2'd2, rv); chk("R1 cmp lo", rv, 32'hFFFF_FFFF);
    rd(2'd3, rv); chk("R1 cmp hi", rv, 32'hFFFF_FFFF);
    chk("R1 irq", irq, 1'b0);
    // R11 read-only fields
    wr(2'd1, 32'h0); rd(2'd1, rv); chk("R11 cfg hi", rv, ROUTE);
    wr(2'd0, 32'h0); rd(2'd0, rv); chk("R11 cap bits", rv, 32'h30);

    // R10 comparator still all ones: no arming
    wr(2'd0, 32'h1);
    load_cnt(64'hFFFF_FFFF_FFFF_FFF0);
    start(); run(40); stop();
    chk("R10 no irq with cmp all ones", nh, 0);

    // vector table walk
    foreach (VECS[k]) begin
      load_cnt(VECS[k].cnt0);
      wr(2'd0, VECS[k].nar ? 32'h9 : 32'h1);
      wr(2'd2, VECS[k].cmp[31:0]);
      wr(2'd3, VECS[k].cmp[63:32]);
      start(); run(60); stop();
      chk($sformatf("R2/R7/R8 vec %0d count", k), nh, VECS[k].nhit);
      chk($sformatf("R2/R7/R8 vec %0d first", k), hits[0], VECS[k].h0);
      if (VECS[k].nhit == 2'd2)
        chk($sformatf("R8 vec %0d second", k), hits[1], VECS[k].h1);
    end

    // R4 set-value loads both and self-clears; R6 periodic reload
    wr(2'd0, 32'h7); wr(2'd2, 32'd50);
    rd(2'd0, rv); chk("R4 setv cleared", rv, 32'h33);
    wr(2'd0, 32'h7); wr(2'd3, 32'd0);
    rd(2'd2, rv); chk("R4 cmp lo", rv, 32'd50);
    rd(2'd3, rv); chk("R4 cmp hi", rv, 32'd0);
    load_cnt(64'd0);
    start(); run(160);
    chk("R6 periodic count", nh, 3);
    chk("R6 hit0", hits[0], 64'd50);
    chk("R6 hit1", hits[1], 64'd100);
    chk("R6 hit2", hits[2], 64'd150);
    // R3 interval-only write
    wr(2'd2, 32'd20);
    rd(2'd2, rv); chk("R3 cmp unchanged", rv, 32'd200);
    nh = 0; run(70); stop();
    chk("R3 next hit", hits[0], 64'd200);
    chk("R3 new interval", hits[1], 64'd220);

    // R6 catch-up without interrupts
    wr(2'd0, 32'h7); wr(2'd2, 32'd10);
    wr(2'd0, 32'h7); wr(2'd3, 32'd0);
    load_cnt(64'd35);
    start(); run(30); stop();
    chk("R6 catch-up first", hits[0], 64'd40);
    chk("R6 catch-up second", hits[1], 64'd50);

    // R5 interval top bit forced clear in narrow mode
    wr(2'd0, 32'hF); wr(2'd2, 32'h8000_0010);
    load_cnt(64'h8000_0000);
    start(); run(40); stop();
    chk("R5 count", nh, 2);
    chk("R5 hit0", hits[0], 64'h8000_0010);
    chk("R5 hit1", hits[1], 64'h8000_0020);

    // R7 truncation and ignored high writes
    wr(2'd0, 32'h1); wr(2'd3, 32'h1234_5678); wr(2'd2, 32'h40);
    rd(2'd3, rv); chk("R7 wide hi", rv, 32'h1234_5678);
    wr(2'd0, 32'h9);
    rd(2'd3, rv); chk("R7 truncated hi", rv, 32'h0);
    wr(2'd3, 32'hABCD);
    rd(2'd3, rv); chk("R7 hi write ignored", rv, 32'h0);

    // R9 disarm on enable clear, arm on enable rise
    wr(2'd0, 32'h1); wr(2'd2, 32'd30); wr(2'd3, 32'd0);
    load_cnt(64'd0);
    start(); run(10);
    wr(2'd0, 32'h0);
    run(40);
    chk("R9 disarmed", nh, 0);
    wr(2'd2, 32'd100);
    wr(2'd0, 32'h1);
    nh = 0; run(60); stop();
    chk("R9 rearm count", nh, 1);
    chk("R9 rearm hit", hits[0], 64'd100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule